// File: doc/BRIEF.md
# Mailbox Address Decoder and Link Switch Controller

This block sits in one node of a mesh of processor nodes, each with four neighbour ports. Every processor address is sorted into one of three classes: private memory, the node's own mailbox, or a neighbour's mailbox reached through one of the four ports. For a neighbour access, a small state machine raises a request on the chosen port and waits for the link to be established. The block also computes the enables for the node's private-bus switch and for the address and data switches of each interconnection port.

When a neighbour reaches into this node, the address it sends arrives with the external flag set. The block clears that single bit before the address goes to local memory. No translator is needed, because port `c` of one node is cabled to port `~c` of the next, so both nodes land on the same physical partition. Each switch control is gated by a per-port isolation mask, which lets software cut off a faulty neighbour.

Address layout, from bit 15 down: bits 15:13 hold the mailbox tag (parameter `MBX_TAG`, default `3'b111`), bit 12 is the external flag, bits 11:10 are the port number, and bits 9:0 are the offset. The state machine has three states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No outgoing request. |
| `ST_ASK` | The request is raised on the latched port. |
| `ST_LINK` | The service and acknowledge signals have both been seen on that port. |

The transitions are:

| Transition | From → To | Condition |
|------------|-----------|-----------|
| `go_ask` | `ST_IDLE` → `ST_ASK` | A valid external access to a port that is not isolated. |
| `go_link` | `ST_ASK` → `ST_LINK` | Service and acknowledge are both seen on the latched port. |
| `abort` | `ST_ASK` → `ST_IDLE` | The valid is dropped or the port becomes isolated. |
| `release` | `ST_LINK` → `ST_IDLE` | The valid is dropped, the acknowledge is dropped, or the port is isolated. |

Top module: `mbx_node_ctrl`

## Requirements
- R1: When `cpu_addr[15:13]` differs from `MBX_TAG`, `acc_kind` is 0 (private).
- R2: When the tag matches and bit 12 is 0, `acc_kind` is 1 (local mailbox).
- R3: A valid access with the tag matching, bit 12 set and port `p=cpu_addr[11:10]` not isolated gives `acc_kind` = 2. One cycle later `req_out` equals `1<<p`, and `req_out` never has more than one bit set.
- R4: An external access to an isolated port gives `acc_kind` = 0 and raises no request. If the latched port becomes isolated while a request is pending, `req_out` clears one cycle later.
- R5: While a request is pending, `req_peer` equals the bitwise complement of the requested port.
- R6: In `ST_ASK`, `svc_out[p]` and `ack_in[p]` both high make `link_up` high one cycle later.
- R7: `pbs_en` is low exactly when some port `c` has `svc_out[c] & ack_in[c] & ~ack_out[c] & ~iso_port[c]`; otherwise it is high.
- R8: `ibs_addr_en[c]` = `((svc_out[c] & ack_in[c]) | ack_out[c]) & ~iso_port[c]`.
- R9: The data switch direction for each port is set as follows, and the two directions of a port are never both enabled:
  - When acting as requester, `ibs_dout[c]` is set for `cpu_wr`=1 and `ibs_din[c]` for `cpu_wr`=0.
  - When acting as the requested node (`ack_out[c]`), `ibs_din[c]` is set for `link_wr`=1 and `ibs_dout[c]` for `link_wr`=0.
  - For a port, the requested role takes precedence over the requester role.
- R10: When any non-isolated `ack_out` bit is high, `mem_addr` is `link_addr` with bit 12 forced to 0. Otherwise `mem_addr` is `cpu_addr`.
- R11: A low `cpu_valid` returns the machine to `ST_IDLE`, so `req_out` is 0 and `link_up` is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor access in progress |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_addr | input | 16 | Processor address |
| link_addr | input | 16 | Address arriving from a neighbour |
| link_wr | input | 1 | Neighbour access is a write |
| svc_out | input | 4 | Per-port service of this node's outgoing request |
| ack_in | input | 4 | Per-port acknowledge from the neighbour |
| ack_out | input | 4 | Per-port acknowledge this node grants to a neighbour |
| iso_port | input | 4 | Per-port isolation mask (1 = faulty) |
| acc_kind | output | 2 | 0 private, 1 local mailbox, 2 external |
| req_out | output | 4 | One-hot request to a neighbour |
| req_peer | output | 2 | Port number on the neighbour's side |
| link_up | output | 1 | Link established for the pending request |
| pbs_en | output | 1 | Private-bus switch closed |
| ibs_addr_en | output | 4 | Interconnection address switch enables |
| ibs_dout | output | 4 | Data switch enable, driving towards the port |
| ibs_din | output | 4 | Data switch enable, receiving from the port |
| mem_addr | output | 16 | Address applied to local memory |

## Verification
A wrong state register shows up as a stuck or missing bit on `req_out` or `link_up`, one clock after the stimulus that should have moved it. That is why every sequencing check samples exactly one edge after its input changes. Errors in the decode and switch terms are combinational, so they appear on `acc_kind`, `pbs_en`, the switch enables or `mem_addr` within the same cycle. A wrongly latched port appears on both `req_out` and `req_peer` for the whole time the request is pending.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 10;
    localparam int PORT_W = 2;
    localparam int NPORT  = 1 << PORT_W;
    localparam int EXT_BIT  = OFF_W + PORT_W;
    localparam int TAG_LSB  = EXT_BIT + 1;
    localparam int TAG_W    = ADDR_W - TAG_LSB;

    typedef enum logic [1:0] {
        ACC_PRIV  = 2'd0,
        ACC_LOCAL = 2'd1,
        ACC_EXT   = 2'd2
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_LINK = 2'd2
    } link_state_t;
endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
    import mbx_pkg::*;
#(
    parameter logic [TAG_W-1:0] MBX_TAG = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPORT-1:0]  iso_port,
    output acc_kind_t         kind,
    output logic [PORT_W-1:0] port
);
    logic tag_hit;
    logic ext_flag;

    always_comb begin
        tag_hit  = (addr[ADDR_W-1:TAG_LSB] == MBX_TAG);
        ext_flag = addr[EXT_BIT];
        port     = addr[EXT_BIT-1:OFF_W];
        if (!tag_hit) begin
            kind = ACC_PRIV;
        end else if (!ext_flag) begin
            kind = ACC_LOCAL;
        end else if (iso_port[port]) begin
            kind = ACC_PRIV;
        end else begin
            kind = ACC_EXT;
        end
    end

    always_comb begin
        a_r4_iso_no_ext: assert (!(kind == ACC_EXT && iso_port[port]));
    end
endmodule

// File: rtl/mbx_req_fsm.sv
module mbx_req_fsm
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              start,
    input  logic [PORT_W-1:0] port,
    input  logic [NPORT-1:0]  iso_port,
    input  logic [NPORT-1:0]  svc_out,
    input  logic [NPORT-1:0]  ack_in,
    output logic [NPORT-1:0]  req_out,
    output logic [PORT_W-1:0] req_peer,
    output logic              link_up
);
    link_state_t       state_q, state_d;
    logic [PORT_W-1:0] port_q, port_d;
    logic              hand_ok;
    logic              cut;

    always_comb begin
        hand_ok = svc_out[port_q] & ack_in[port_q];
        cut     = !cpu_valid || iso_port[port_q];
        state_d = state_q;
        port_d  = port_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid && start) begin
                    state_d = ST_ASK;        // go_ask
                    port_d  = port;
                end
            end
            ST_ASK: begin
                if (cut)          state_d = ST_IDLE;  // abort
                else if (hand_ok) state_d = ST_LINK;  // go_link
            end
            ST_LINK: begin
                if (cut || !ack_in[port_q]) state_d = ST_IDLE;  // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
        end else begin
            state_q <= state_d;
            port_q  <= port_d;
        end
    end

    always_comb begin
        req_out  = '0;
        link_up  = 1'b0;
        req_peer = ~port_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ASK:  req_out[port_q] = 1'b1;
            ST_LINK: begin
                req_out[port_q] = 1'b1;
                link_up         = 1'b1;
            end
            default: ;
        endcase
    end

    a_r3_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_out));
    a_r11_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> (req_out == '0 && !link_up));
    a_r6_link_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out != '0 && !link_up && cpu_valid && (svc_out & ack_in & req_out) != '0
         && (iso_port & req_out) == '0) |=> link_up);
endmodule

// File: rtl/mbx_switch_ctrl.sv
module mbx_switch_ctrl
    import mbx_pkg::*;
(
    input  logic             cpu_wr,
    input  logic             link_wr,
    input  logic [NPORT-1:0] svc_out,
    input  logic [NPORT-1:0] ack_in,
    input  logic [NPORT-1:0] ack_out,
    input  logic [NPORT-1:0] iso_port,
    output logic             pbs_en,
    output logic [NPORT-1:0] ibs_addr_en,
    output logic [NPORT-1:0] ibs_dout,
    output logic [NPORT-1:0] ibs_din,
    output logic             serving
);
    logic [NPORT-1:0] as_req;
    logic [NPORT-1:0] as_rsp;

    for (genvar c = 0; c < NPORT; c++) begin : g_port
        always_comb begin
            as_rsp[c]      = ack_out[c] & ~iso_port[c];
            as_req[c]      = svc_out[c] & ack_in[c] & ~ack_out[c] & ~iso_port[c];
            ibs_addr_en[c] = ((svc_out[c] & ack_in[c]) | ack_out[c]) & ~iso_port[c];
            ibs_dout[c]    = (as_req[c] & cpu_wr) | (as_rsp[c] & ~link_wr);
            ibs_din[c]     = (as_req[c] & ~cpu_wr) | (as_rsp[c] & link_wr);
        end
        always_comb begin
            a_r9_dir_excl: assert (!(ibs_dout[c] && ibs_din[c]));
        end
    end

    always_comb begin
        pbs_en  = ~(|as_req);
        serving = |as_rsp;
    end

    always_comb begin
        a_r7_pbs_open: assert (pbs_en || (ibs_addr_en != '0));
    end
endmodule

// File: rtl/mbx_node_ctrl.sv
module mbx_node_ctrl
    import mbx_pkg::*;
#(
    parameter logic [TAG_W-1:0] MBX_TAG = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_valid,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_addr,
    input  logic [15:0] link_addr,
    input  logic        link_wr,
    input  logic [3:0]  svc_out,
    input  logic [3:0]  ack_in,
    input  logic [3:0]  ack_out,
    input  logic [3:0]  iso_port,
    output logic [1:0]  acc_kind,
    output logic [3:0]  req_out,
    output logic [1:0]  req_peer,
    output logic        link_up,
    output logic        pbs_en,
    output logic [3:0]  ibs_addr_en,
    output logic [3:0]  ibs_dout,
    output logic [3:0]  ibs_din,
    output logic [15:0] mem_addr
);
    acc_kind_t         kind;
    logic [PORT_W-1:0] port;
    logic              serving;

    mbx_addr_decode #(.MBX_TAG(MBX_TAG)) u_dec (
        .addr(cpu_addr), .iso_port(iso_port), .kind(kind), .port(port)
    );

    mbx_req_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid),
        .start(kind == ACC_EXT), .port(port), .iso_port(iso_port),
        .svc_out(svc_out), .ack_in(ack_in),
        .req_out(req_out), .req_peer(req_peer), .link_up(link_up)
    );

    mbx_switch_ctrl u_sw (
        .cpu_wr(cpu_wr), .link_wr(link_wr), .svc_out(svc_out), .ack_in(ack_in),
        .ack_out(ack_out), .iso_port(iso_port), .pbs_en(pbs_en),
        .ibs_addr_en(ibs_addr_en), .ibs_dout(ibs_dout), .ibs_din(ibs_din),
        .serving(serving)
    );

    always_comb begin
        acc_kind = kind;
        if (serving) begin
            mem_addr          = link_addr;
            mem_addr[EXT_BIT] = 1'b0;
        end else begin
            mem_addr = cpu_addr;
        end
    end

    a_r10_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_out & ~iso_port) != '0) |-> !mem_addr[EXT_BIT]);
endmodule

// File: tb/tb_mbx_node_ctrl.sv
module tb_mbx_node_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cpu_valid = 0, cpu_wr = 0, link_wr = 0;
    logic [15:0] cpu_addr = 0, link_addr = 0;
    logic [3:0]  svc_out = 0, ack_in = 0, ack_out = 0, iso_port = 0;
    logic [1:0]  acc_kind, req_peer;
    logic [3:0]  req_out, ibs_addr_en, ibs_dout, ibs_din;
    logic        link_up, pbs_en;
    logic [15:0] mem_addr;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    mbx_node_ctrl dut (.*);

    function automatic logic [15:0] mk(input logic [2:0] t, input logic e,
                                       input logic [1:0] p, input logic [9:0] o);
        return {t, e, p, o};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge_settle();
        @(posedge clk); #1;
    endtask

    task automatic idle_all();
        @(negedge clk);
        cpu_valid = 0; cpu_wr = 0; link_wr = 0; cpu_addr = 0; link_addr = 0;
        svc_out = 0; ack_in = 0; ack_out = 0; iso_port = 0;
        edge_settle();
    endtask

    task automatic t_reset();
        #1;
        check("R11 reset req_out", req_out, 0);
        check("R11 reset link_up", link_up, 0);
        check("R7 reset pbs_en", pbs_en, 1);
    endtask

    task automatic t_decode();
        @(negedge clk);
        cpu_addr = mk(3'b101, 1, 2'b10, 10'h3);  #1;
        check("R1 private tag", acc_kind, 0);
        cpu_addr = mk(3'b011, 0, 2'b00, 10'h0);  #1;
        check("R1 private tag2", acc_kind, 0);
        cpu_addr = mk(3'b111, 0, 2'b11, 10'h2AA); #1;
        check("R2 local mailbox", acc_kind, 1);
        cpu_addr = mk(3'b111, 1, 2'b00, 10'h1); #1;
        check("R3 external kind", acc_kind, 2);
        check("R10 no serve passthrough", mem_addr, cpu_addr);
    endtask

    task automatic t_request();
        @(negedge clk);
        cpu_valid = 1; cpu_wr = 1; cpu_addr = mk(3'b111, 1, 2'b10, 10'h40);
        edge_settle();
        check("R3 req_out port2", req_out, 4'b0100);
        check("R5 peer of 2", req_peer, 2'b01);
        check("R6 not yet linked", link_up, 0);
        edge_settle();
        check("R6 waits without ack", link_up, 0);
        @(negedge clk);
        svc_out = 4'b0100; ack_in = 4'b0100; #1;
        check("R7 pbs opens", pbs_en, 0);
        check("R9 write drives out", ibs_dout, 4'b0100);
        edge_settle();
        check("R6 linked", link_up, 1);
        check("R3 req held", req_out, 4'b0100);
        @(negedge clk);
        cpu_valid = 0;
        edge_settle();
        check("R11 req dropped", req_out, 0);
        check("R11 link dropped", link_up, 0);
        idle_all();
        @(negedge clk);
        cpu_valid = 1; cpu_addr = mk(3'b111, 1, 2'b00, 10'h0);
        edge_settle();
        check("R3 req_out port0", req_out, 4'b0001);
        check("R5 peer of 0", req_peer, 2'b11);
        idle_all();
    endtask

    task automatic t_isolate();
        @(negedge clk);
        iso_port = 4'b0010; cpu_valid = 1; cpu_addr = mk(3'b111, 1, 2'b01, 10'h5); #1;
        check("R4 isolated kind", acc_kind, 0);
        edge_settle();
        check("R4 isolated no req", req_out, 0);
        @(negedge clk);
        cpu_addr = mk(3'b111, 1, 2'b11, 10'h5);
        edge_settle();
        check("R3 req_out port3", req_out, 4'b1000);
        check("R5 peer of 3", req_peer, 2'b00);
        @(negedge clk);
        iso_port = 4'b1010;
        edge_settle();
        check("R4 isolation aborts", req_out, 0);
        idle_all();
    endtask

    task automatic t_switch();
        @(negedge clk);
        svc_out = 4'b0001; ack_in = 4'b0001; cpu_wr = 1; #1;
        check("R8 addr en req side", ibs_addr_en, 4'b0001);
        check("R9 req write out", ibs_dout, 4'b0001);
        check("R9 req write in", ibs_din, 4'b0000);
        cpu_wr = 0; #1;
        check("R9 req read in", ibs_din, 4'b0001);
        check("R9 req read out", ibs_dout, 4'b0000);
        svc_out = 4'b0001; ack_in = 0; #1;
        check("R7 svc alone keeps closed", pbs_en, 1);
        check("R8 svc alone no en", ibs_addr_en, 0);
        svc_out = 0; ack_out = 4'b0010; link_wr = 1; #1;
        check("R8 addr en rsp side", ibs_addr_en, 4'b0010);
        check("R9 rsp write in", ibs_din, 4'b0010);
        check("R7 rsp keeps pbs", pbs_en, 1);
        link_wr = 0; #1;
        check("R9 rsp read out", ibs_dout, 4'b0010);
        iso_port = 4'b0010; #1;
        check("R8 isolated masked", ibs_addr_en, 0);
        check("R9 isolated masked", ibs_dout | ibs_din, 0);
        iso_port = 0; svc_out = 4'b1000; ack_in = 4'b1000; iso_port = 4'b1000; #1;
        check("R7 isolated req keeps pbs", pbs_en, 1);
        idle_all();
    endtask

    task automatic t_rewrite();
        @(negedge clk);
        cpu_addr = 16'h0123; link_addr = mk(3'b111, 1, 2'b01, 10'h155);
        ack_out = 4'b0100; #1;
        check("R10 flag cleared", mem_addr, mk(3'b111, 0, 2'b01, 10'h155));
        ack_out = 0; #1;
        check("R10 local passthrough", mem_addr, 16'h0123);
        ack_out = 4'b0100; iso_port = 4'b0100; #1;
        check("R10 isolated ignored", mem_addr, 16'h0123);
        idle_all();
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #12 rst_n = 1;
        t_reset();
        t_decode();
        t_request();
        t_isolate();
        t_switch();
        t_rewrite();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule